// File: doc/BRIEF.md
# Opcode-Driven SPI Transfer Sequencer

This block is a half-duplex SPI master run by a small byte program. The host loads a 64-bit program word, and the engine executes its opcodes one byte at a time, starting with the top byte. Each opcode either selects a peripheral, shifts bytes out of a single 64-bit transmit word, shifts bytes into a single 64-bit receive word, or ends the program. A typical program selects a peripheral, sends a command, optionally reads a short reply, and then releases the select line.

The host has no FIFO. It exchanges data with the engine through one transmit word and one receive word. Full flags provide the handshake, and overrun and underrun flags record misuse. All of these flags appear in a status word, along with a one-hot view of the sequencer state. A clock configuration word sets the SCK divider and the behaviour when transmit data is missing. A two-step write pattern to the same word acts as a soft reset.

Top module: `spiseq_top`

## Requirements
- R1: After reset, every `spi_cs_n` line is high, `spi_sck` and `spi_mosi` are low, and the status word (address 0x8) reads exactly 0x0001_0000_0000_0000. In that word only the idle flag is set.
- R2: A write to the program word (address 0x7) while the engine is idle starts execution at bits 63:56 and moves toward bit 0.
  - Opcode 0x00 ends the program.
  - After eight opcodes the engine also returns to idle.
  - Status bits 55:48 hold the state one-hot: bit 48 idle, bit 49 decoding, bit 50 waiting for transmit data, bit 51 shifting.
- R3: Opcode 0x1N with N from 1 to CS_NUM drives `spi_cs_n[N-1]` low and all other select lines high. N = 0, or N above CS_NUM, drives all select lines high. At most one select line is ever low.
- R4: Opcode 0x3N (N from 1 to 8; larger values are treated as 8) sends the top N bytes of the transmit word, MSB first, starting at bit 63.
  - SPI mode 0 applies: SCK idles low and MOSI is held stable while SCK is high.
  - The engine takes a fresh transmit word for each such opcode.
- R5: SCK runs at the system clock divided by 2×(D+1), where D is clock configuration bits 63:52 (address 0x3).
- R6: Writing the transmit word (address 0x5) sets transmit-full (status bit 59). The flag clears when a shift-out opcode takes the word.
- R7: Writing the transmit word while transmit-full is set raises transmit overrun (status bit 58) and leaves the stored word unchanged.
- R8: A shift-out opcode that finds the transmit word empty behaves according to clock configuration bit 0.
  - If bit 0 is 0, the engine stalls with no SCK activity until the host writes the word.
  - If bit 0 is 1, the engine raises transmit underrun (status bit 57) and skips the opcode.
- R9: Opcode 0x4N shifts in N bytes and samples MISO on rising SCK edges. MOSI stays low during the shift.
  - The bytes are right-aligned in the receive word (address 0x6): the last byte lands in bits 7:0 and the unused upper bytes are zero.
  - Receive-full (status bit 63) is set when the shift completes.
- R10: Reading the receive word clears receive-full. Reading it while receive-full is clear raises receive underrun (status bit 61).
- R11: If a shift-in completes while receive-full is still set and no read happens in that cycle, the engine raises receive overrun (status bit 62) and keeps the newest data.
- R12: Any write to the status word clears the four overrun and underrun flags.
- R13: A clock configuration write with bits 39:36 = 0101, followed by a second one with bits 39:36 = 1010, performs a soft reset.
  - The sequencer returns to idle and all select lines go high.
  - Both full flags clear.
  - Neither of these writes changes the stored divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects apply at the next edge |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |
| spi_cs_n | output | CS_NUM | Active-low peripheral selects |

## Verification
The sequencer state is visible in the status word on the very next read, and the select lines show the last select opcode at once. A wrong program index or wrong byte order therefore shows up as the wrong select line when the program ends. A corrupted full flag shows up in two ways within one transfer: an SCK burst that should not occur, or a stall that should not occur. Shifter misalignment shows up as a shifted receive word, or as the wrong MOSI bits captured on the first rising edges.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;

  localparam int WORD_W = 64;

  // host register map
  localparam logic [3:0] ADDR_CLKCFG  = 4'h3;
  localparam logic [3:0] ADDR_TXDATA  = 4'h5;
  localparam logic [3:0] ADDR_RXDATA  = 4'h6;
  localparam logic [3:0] ADDR_PROGRAM = 4'h7;
  localparam logic [3:0] ADDR_STATUS  = 4'h8;

  // clock configuration fields
  localparam int DIV_HI      = 63;
  localparam int DIV_LO      = 52;
  localparam int DIV_W       = DIV_HI - DIV_LO + 1;
  localparam int NOSTALL_BIT = 0;
  localparam int RSTPAT_LO   = 36;
  localparam logic [3:0] RST_ARM  = 4'b0101;
  localparam logic [3:0] RST_FIRE = 4'b1010;

  // status fields
  localparam int ST_RXFULL  = 63;
  localparam int ST_RXOVR   = 62;
  localparam int ST_RXUND   = 61;
  localparam int ST_TXFULL  = 59;
  localparam int ST_TXOVR   = 58;
  localparam int ST_TXUND   = 57;
  localparam int ST_STATE_LO = 48;

  // opcode classes (upper nibble)
  localparam logic [3:0] OPC_CTRL = 4'h0;
  localparam logic [3:0] OPC_SEL  = 4'h1;
  localparam logic [3:0] OPC_OUT  = 4'h3;
  localparam logic [3:0] OPC_IN   = 4'h4;
  localparam logic [3:0] MAX_BYTES = 4'd8;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_DECODE = 2'd1,
    SQ_WAITTX = 2'd2,
    SQ_SHIFT  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/spiseq_clkdiv.sv
module spiseq_clkdiv
  import spiseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $stable(div)) |-> (cnt_q <= div)); // R5

endmodule

// File: rtl/spiseq_shifter.sv
module spiseq_shifter
  import spiseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic              rx_mode,
  input  logic [3:0]        nbytes,
  input  logic [WORD_W-1:0] txword,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [WORD_W-1:0] rxword
);

  localparam int BITS_W = $clog2(WORD_W) + 1;

  logic              busy_q, busy_d;
  logic              sck_q, sck_d;
  logic              done_q, done_d;
  logic [WORD_W-1:0] txsh_q, txsh_d;
  logic [WORD_W-1:0] rxsh_q, rxsh_d;
  logic [BITS_W-1:0] left_q, left_d;

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    done_d = 1'b0;
    txsh_d = txsh_q;
    rxsh_d = rxsh_q;
    left_d = left_q;
    if (abort) begin
      busy_d = 1'b0;
      sck_d  = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      sck_d  = 1'b0;
      txsh_d = rx_mode ? '0 : txword;
      rxsh_d = '0;
      left_d = {nbytes, 3'b000};
    end else if (busy_q && tick) begin
      if (!sck_q) begin
        sck_d  = 1'b1;
        rxsh_d = {rxsh_q[WORD_W-2:0], miso};
      end else begin
        sck_d = 1'b0;
        if (left_q == BITS_W'(1)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          txsh_d = {txsh_q[WORD_W-2:0], 1'b0};
          left_d = left_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      txsh_q <= '0;
      rxsh_q <= '0;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      done_q <= done_d;
      txsh_q <= txsh_d;
      rxsh_q <= rxsh_d;
      left_q <= left_d;
    end
  end

  assign busy   = busy_q;
  assign sck    = sck_q;
  assign mosi   = busy_q & txsh_q[WORD_W-1];
  assign done   = done_q;
  assign rxword = rxsh_q;

  AST_SCK_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q); // R4
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(mosi)); // R4
  AST_RX_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start) && $past(rx_mode) && !$past(abort)) |-> !mosi); // R9

endmodule

// File: rtl/spiseq_top.sv
module spiseq_top
  import spiseq_pkg::*;
#(
  parameter int CS_NUM = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [CS_NUM-1:0] spi_cs_n
);

  localparam int OPS     = WORD_W / 8;
  localparam int IDX_W   = $clog2(OPS) + 1;
  localparam int CLK_PAD = WORD_W - DIV_W - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  // state
  seq_state_t        st_q, st_d;
  logic [WORD_W-1:0] prog_q, prog_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CS_NUM-1:0] cs_q, cs_d;
  logic [WORD_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic              txf_q, txf_d, rxf_q, rxf_d;
  logic              txo_q, txo_d, txu_q, txu_d;
  logic              rxo_q, rxo_d, rxu_q, rxu_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              nostall_q, nostall_d;
  logic              armed_q, armed_d;
  logic              rxop_q, rxop_d;

  // host decode
  logic       wr_clk, wr_tx, wr_prog, wr_st, rd_rx, soft_rst;
  logic [3:0] rst_pat;

  assign wr_clk   = reg_wr && (reg_addr == ADDR_CLKCFG);
  assign wr_tx    = reg_wr && (reg_addr == ADDR_TXDATA);
  assign wr_prog  = reg_wr && (reg_addr == ADDR_PROGRAM);
  assign wr_st    = reg_wr && (reg_addr == ADDR_STATUS);
  assign rd_rx    = reg_rd && (reg_addr == ADDR_RXDATA);
  assign rst_pat  = reg_wdata[RSTPAT_LO+3:RSTPAT_LO];
  assign soft_rst = wr_clk && (rst_pat == RST_FIRE) && armed_q;

  // current opcode
  logic [7:0] op;
  logic [3:0] op_n;
  assign op   = prog_q[WORD_W-1 -: 8];
  assign op_n = (op[3:0] > MAX_BYTES) ? MAX_BYTES : op[3:0];

  // shifter link
  logic              sh_start, sh_rx, sh_busy, sh_done, sh_tick;
  logic [WORD_W-1:0] sh_rxword;

  spiseq_clkdiv u_clkdiv (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en    (sh_busy),
    .div   (div_q),
    .tick  (sh_tick)
  );

  spiseq_shifter u_shifter (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .abort   (soft_rst),
    .start   (sh_start),
    .rx_mode (sh_rx),
    .nbytes  (op_n),
    .txword  (tx_q),
    .tick    (sh_tick),
    .miso    (spi_miso),
    .busy    (sh_busy),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .done    (sh_done),
    .rxword  (sh_rxword)
  );

  // next state
  always_comb begin
    st_d      = st_q;
    prog_d    = prog_q;
    idx_d     = idx_q;
    cs_d      = cs_q;
    tx_d      = tx_q;
    rx_d      = rx_q;
    txf_d     = txf_q;
    rxf_d     = rxf_q;
    txo_d     = txo_q;
    txu_d     = txu_q;
    rxo_d     = rxo_q;
    rxu_d     = rxu_q;
    div_d     = div_q;
    nostall_d = nostall_q;
    armed_d   = armed_q;
    rxop_d    = rxop_q;
    sh_start  = 1'b0;
    sh_rx     = 1'b0;

    // host side
    if (wr_clk) begin
      if (rst_pat == RST_ARM) begin
        armed_d = 1'b1;
      end else if (rst_pat == RST_FIRE) begin
        armed_d = 1'b0;
      end else begin
        div_d     = reg_wdata[DIV_HI:DIV_LO];
        nostall_d = reg_wdata[NOSTALL_BIT];
        armed_d   = 1'b0;
      end
    end
    if (wr_tx) begin
      if (txf_q) begin
        txo_d = 1'b1;
      end else begin
        tx_d  = reg_wdata;
        txf_d = 1'b1;
      end
    end
    if (rd_rx) begin
      if (rxf_q) rxf_d = 1'b0;
      else       rxu_d = 1'b1;
    end
    if (wr_st) begin
      txo_d = 1'b0;
      txu_d = 1'b0;
      rxo_d = 1'b0;
      rxu_d = 1'b0;
    end

    // sequencer
    unique case (st_q)
      SQ_IDLE: begin
        if (wr_prog) begin
          prog_d = reg_wdata;
          idx_d  = '0;
          st_d   = SQ_DECODE;
        end
      end
      SQ_DECODE: begin
        if (idx_q == IDX_W'(OPS)) begin
          st_d = SQ_IDLE;
        end else begin
          prog_d = {prog_q[WORD_W-9:0], 8'h00};
          idx_d  = idx_q + 1'b1;
          unique case (op[7:4])
            OPC_CTRL: begin
              if (op[3:0] == 4'h0) begin
                prog_d = prog_q;
                idx_d  = idx_q;
                st_d   = SQ_IDLE;
              end
            end
            OPC_SEL: begin
              for (int i = 0; i < CS_NUM; i++)
                cs_d[i] = (op[3:0] == 4'(i + 1));
            end
            OPC_OUT: begin
              if (op_n != 4'h0) begin
                if (txf_q) begin
                  sh_start = 1'b1;
                  txf_d    = 1'b0;
                  rxop_d   = 1'b0;
                  st_d     = SQ_SHIFT;
                end else if (nostall_q) begin
                  txu_d = 1'b1;
                end else begin
                  prog_d = prog_q;
                  idx_d  = idx_q;
                  st_d   = SQ_WAITTX;
                end
              end
            end
            OPC_IN: begin
              if (op_n != 4'h0) begin
                sh_start = 1'b1;
                sh_rx    = 1'b1;
                rxop_d   = 1'b1;
                st_d     = SQ_SHIFT;
              end
            end
            default: ;
          endcase
        end
      end
      SQ_WAITTX: begin
        if (txf_q) st_d = SQ_DECODE;
      end
      SQ_SHIFT: begin
        if (sh_done) begin
          if (rxop_q) begin
            rx_d  = sh_rxword;
            rxf_d = 1'b1;
            if (rxf_q && !rd_rx) rxo_d = 1'b1;
          end
          st_d = SQ_DECODE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase

    if (soft_rst) begin
      st_d  = SQ_IDLE;
      cs_d  = '0;
      txf_d = 1'b0;
      rxf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q      <= SQ_IDLE;
      prog_q    <= '0;
      idx_q     <= '0;
      cs_q      <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      txf_q     <= 1'b0;
      rxf_q     <= 1'b0;
      txo_q     <= 1'b0;
      txu_q     <= 1'b0;
      rxo_q     <= 1'b0;
      rxu_q     <= 1'b0;
      div_q     <= '0;
      nostall_q <= 1'b0;
      armed_q   <= 1'b0;
      rxop_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      prog_q    <= prog_d;
      idx_q     <= idx_d;
      cs_q      <= cs_d;
      tx_q      <= tx_d;
      rx_q      <= rx_d;
      txf_q     <= txf_d;
      rxf_q     <= rxf_d;
      txo_q     <= txo_d;
      txu_q     <= txu_d;
      rxo_q     <= rxo_d;
      rxu_q     <= rxu_d;
      div_q     <= div_d;
      nostall_q <= nostall_d;
      armed_q   <= armed_d;
      rxop_q    <= rxop_d;
    end
  end

  assign spi_cs_n = ~cs_q;

  // status and read mux
  logic [WORD_W-1:0] status_w;
  always_comb begin
    status_w = '0;
    status_w[ST_RXFULL] = rxf_q;
    status_w[ST_RXOVR]  = rxo_q;
    status_w[ST_RXUND]  = rxu_q;
    status_w[ST_TXFULL] = txf_q;
    status_w[ST_TXOVR]  = txo_q;
    status_w[ST_TXUND]  = txu_q;
    status_w[ST_STATE_LO +: 8] = {4'b0000, st_q == SQ_SHIFT, st_q == SQ_WAITTX,
                                  st_q == SQ_DECODE, st_q == SQ_IDLE};
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CLKCFG:  reg_rdata = {div_q, {CLK_PAD{1'b0}}, nostall_q};
      ADDR_TXDATA:  reg_rdata = tx_q;
      ADDR_RXDATA:  reg_rdata = rx_q;
      ADDR_PROGRAM: reg_rdata = prog_q;
      ADDR_STATUS:  reg_rdata = status_w;
      default:      reg_rdata = '0;
    endcase
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(~spi_cs_n)); // R3
  AST_IDLE_NO_SCK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == SQ_IDLE) |-> !spi_sck); // R2
  AST_TXFULL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_tx && !txf_q) |=> txf_q); // R6
  AST_TXOVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_tx && txf_q) |=> (txo_q && $stable(tx_q))); // R7
  AST_RXUND_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_rx && !rxf_q) |=> rxu_q); // R10
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == SQ_WAITTX) |-> !sh_busy); // R8
  AST_SOFT_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    soft_rst |=> (st_q == SQ_IDLE && !txf_q && !rxf_q && &spi_cs_n)); // R13

endmodule

// File: tb/spiseq_top_test.sv
`timescale 1ns/1ps
module spiseq_top_test;

  localparam int CS_NUM = 4;
  localparam logic [3:0] A_CLK = 4'h3, A_TX = 4'h5, A_RX = 4'h6, A_PRG = 4'h7, A_ST = 4'h8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr, reg_rd;
  logic [3:0]        reg_addr;
  logic [63:0]       reg_wdata, reg_rdata;
  logic              spi_sck, spi_mosi, spi_miso;
  logic [CS_NUM-1:0] spi_cs_n;

  always #2 clk = ~clk;

  spiseq_top #(.CS_NUM(CS_NUM)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  int n_chk = 0;
  int n_fail = 0;

  // peripheral model
  int                rises = 0;
  int                falls = 0;
  int                fbase = 0;
  logic [63:0]       mosi_cap = '0;
  logic [63:0]       pat = '0;
  logic [CS_NUM-1:0] cs_at_rise = '1;
  time               t_last = 0;
  time               t_per = 0;
  logic [5:0]        bit_i;

  always @(posedge spi_sck) begin
    mosi_cap   = {mosi_cap[62:0], spi_mosi};
    rises      = rises + 1;
    t_per      = $time - t_last;
    t_last     = $time;
    cs_at_rise = spi_cs_n;
  end
  always @(negedge spi_sck) falls = falls + 1;
  assign bit_i    = 6'(falls - fbase);
  assign spi_miso = pat[6'd63 - bit_i];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    logic [63:0] s;
    bit ok;
    ok = 1'b0;
    s = '0;
    for (int i = 0; i < 4000; i++) begin
      rd(A_ST, s);
      if (s[48]) begin ok = 1'b1; break; end
    end
    chk(ok, req, s, 64'h0001_0000_0000_0000);
  endtask

  task automatic t_reset();
    logic [63:0] s;
    rd(A_ST, s);
    chk(s == 64'h0001_0000_0000_0000, "R1 status", s, 64'h0001_0000_0000_0000);
    chk(spi_cs_n == 4'hF && !spi_sck && !spi_mosi, "R1 pins",
        {spi_cs_n, spi_sck, spi_mosi}, {4'hF, 2'b00});
  endtask

  task automatic t_tx_basic();
    logic [63:0] s;
    int r0;
    wr(A_CLK, 64'h0010_0000_0000_0000);
    wr(A_TX, 64'hA5C3_0000_0000_0000);
    rd(A_ST, s);
    chk(s[59], "R6 tx full set", s, 64'h0800_0000_0000_0000);
    r0 = rises;
    wr(A_PRG, 64'h1132_1000_0000_0000);
    wait_idle("R2 idle after tx");
    chk(rises - r0 == 16, "R4 edge count", 64'(rises - r0), 64'd16);
    chk(mosi_cap[15:0] == 16'hA5C3, "R4 mosi bytes", mosi_cap[15:0], 64'hA5C3);
    chk(cs_at_rise == 4'b1110, "R3 select during tx", cs_at_rise, 4'b1110);
    chk(spi_cs_n == 4'hF, "R3 deselect at end", spi_cs_n, 4'hF);
    chk(t_per == 16, "R5 period div1", t_per, 64'd16);
    rd(A_ST, s);
    chk(!s[59], "R6 tx full cleared", s, 64'h0001_0000_0000_0000);
  endtask

  task automatic t_divider();
    logic [63:0] s;
    wr(A_CLK, 64'h0030_0000_0000_0000);
    rd(A_CLK, s);
    chk(s == 64'h0030_0000_0000_0000, "R5 divider readback", s, 64'h0030_0000_0000_0000);
    wr(A_TX, 64'h5500_0000_0000_0000);
    wr(A_PRG, 64'h1131_1000_0000_0000);
    wait_idle("R5 idle");
    chk(t_per == 32, "R5 period div3", t_per, 64'd32);
    chk(mosi_cap[7:0] == 8'h55, "R4 single byte", mosi_cap[7:0], 64'h55);
    wr(A_CLK, 64'h0010_0000_0000_0000);
  endtask

  task automatic t_tx_overrun();
    logic [63:0] s;
    wr(A_ST, 64'h0);
    wr(A_TX, 64'h1111_1111_1111_1111);
    wr(A_TX, 64'h2222_2222_2222_2222);
    rd(A_ST, s);
    chk(s[58] && s[59], "R7 overrun flag", s, 64'h0C01_0000_0000_0000);
    rd(A_TX, s);
    chk(s == 64'h1111_1111_1111_1111, "R7 word kept", s, 64'h1111_1111_1111_1111);
    wr(A_PRG, 64'h1138_1000_0000_0000);
    wait_idle("R4 eight bytes");
    chk(mosi_cap == 64'h1111_1111_1111_1111, "R4 eight byte data", mosi_cap, 64'h1111_1111_1111_1111);
    wr(A_ST, 64'h0);
  endtask

  task automatic t_stall();
    logic [63:0] s;
    int r0;
    r0 = rises;
    wr(A_PRG, 64'h1231_1000_0000_0000);
    repeat (20) @(negedge clk);
    rd(A_ST, s);
    chk(s[50] && !s[48], "R8 stalled state", s, 64'h0004_0000_0000_0000);
    chk(rises == r0, "R8 no sck while stalled", 64'(rises - r0), 64'd0);
    chk(spi_cs_n == 4'b1101, "R3 select 2 held", spi_cs_n, 4'b1101);
    wr(A_TX, 64'h3C00_0000_0000_0000);
    wait_idle("R8 resume");
    chk(mosi_cap[7:0] == 8'h3C && rises - r0 == 8, "R8 data after stall",
        mosi_cap[7:0], 64'h3C);
  endtask

  task automatic t_nostall();
    logic [63:0] s;
    int r0;
    wr(A_CLK, 64'h0010_0000_0000_0001);
    wr(A_ST, 64'h0);
    r0 = rises;
    wr(A_PRG, 64'h1231_1000_0000_0000);
    wait_idle("R8 skip idle");
    rd(A_ST, s);
    chk(s[57], "R8 underrun flag", s, 64'h0201_0000_0000_0000);
    chk(rises == r0, "R8 opcode skipped", 64'(rises - r0), 64'd0);
    wr(A_CLK, 64'h0010_0000_0000_0000);
    wr(A_ST, 64'h0);
  endtask

  task automatic t_rx();
    logic [63:0] s;
    int r0;
    pat   = 64'h5A3C_0000_0000_0000;
    fbase = falls;
    r0    = rises;
    wr(A_PRG, 64'h1242_1000_0000_0000);
    wait_idle("R9 idle");
    rd(A_ST, s);
    chk(s[63], "R9 rx full", s, 64'h8001_0000_0000_0000);
    chk(rises - r0 == 16 && mosi_cap[15:0] == 16'h0, "R9 mosi low", mosi_cap[15:0], 64'h0);
    chk(cs_at_rise == 4'b1101, "R3 select during rx", cs_at_rise, 4'b1101);
    rd(A_RX, s);
    chk(s == 64'h0000_0000_0000_5A3C, "R9 right aligned", s, 64'h5A3C);
    rd(A_ST, s);
    chk(!s[63], "R10 read clears full", s, 64'h0001_0000_0000_0000);
    rd(A_RX, s);
    rd(A_ST, s);
    chk(s[61] && !s[63], "R10 underrun", s, 64'h2001_0000_0000_0000);
  endtask

  task automatic t_rx_overrun();
    logic [63:0] s;
    wr(A_ST, 64'h0);
    pat   = 64'h9600_0000_0000_0000;
    fbase = falls;
    wr(A_PRG, 64'h1141_1000_0000_0000);
    wait_idle("R11 first");
    pat   = 64'h6900_0000_0000_0000;
    fbase = falls;
    wr(A_PRG, 64'h1141_1000_0000_0000);
    wait_idle("R11 second");
    rd(A_ST, s);
    chk(s[62] && s[63], "R11 overrun", s, 64'hC001_0000_0000_0000);
    rd(A_RX, s);
    chk(s == 64'h69, "R11 newest kept", s, 64'h69);
  endtask

  task automatic t_status_clear();
    logic [63:0] s;
    rd(A_RX, s);
    rd(A_ST, s);
    chk(s[61], "R12 precondition", s, 64'h2001_0000_0000_0000);
    wr(A_ST, 64'h0);
    rd(A_ST, s);
    chk((s & 64'h6600_0000_0000_0000) == 64'h0, "R12 errors cleared", s, 64'h0001_0000_0000_0000);
  endtask

  task automatic t_select();
    wr(A_PRG, 64'h1300_0000_0000_0000);
    wait_idle("R3 idle");
    chk(spi_cs_n == 4'b1011, "R3 select 3", spi_cs_n, 4'b1011);
    wr(A_PRG, 64'h1700_0000_0000_0000);
    wait_idle("R3 idle");
    chk(spi_cs_n == 4'b1111, "R3 out of range", spi_cs_n, 4'b1111);
  endtask

  task automatic t_order();
    wr(A_PRG, 64'h1112_1314_1112_1314);
    wait_idle("R2 eight ops");
    chk(spi_cs_n == 4'b0111, "R2 msb first all eight", spi_cs_n, 4'b0111);
    wr(A_PRG, 64'h1100_1200_0000_0000);
    wait_idle("R2 stop");
    chk(spi_cs_n == 4'b1110, "R2 stop opcode", spi_cs_n, 4'b1110);
    wr(A_PRG, 64'h1000_0000_0000_0000);
    wait_idle("R2 deselect");
  endtask

  task automatic t_soft_reset();
    logic [63:0] s;
    pat   = 64'hFF00_0000_0000_0000;
    fbase = falls;
    wr(A_PRG, 64'h1241_1000_0000_0000);
    wait_idle("R13 fill rx");
    wr(A_PRG, 64'h1131_1000_0000_0000);
    repeat (10) @(negedge clk);
    wr(A_CLK, 64'h0000_0050_0000_0000);
    wr(A_CLK, 64'h0000_00A0_0000_0000);
    rd(A_ST, s);
    chk(s[48] && !s[63] && !s[59], "R13 idle and flags", s, 64'h0001_0000_0000_0000);
    chk(spi_cs_n == 4'hF, "R13 deselect", spi_cs_n, 4'hF);
    rd(A_CLK, s);
    chk(s == 64'h0010_0000_0000_0000, "R13 divider kept", s, 64'h0010_0000_0000_0000);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_tx_basic();
    t_divider();
    t_tx_overrun();
    t_stall();
    t_nostall();
    t_rx();
    t_rx_overrun();
    t_status_clear();
    t_select();
    t_order();
    t_soft_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule